// File: doc/BRIEF.md
# Special Register Access Decoder

This block serves the move-to and move-from special-register instructions of a small 32-bit core. Each request carries a 5-bit group and an 11-bit index. The block joins them into a 16-bit register number, with the group in bits [15:11] and the index in bits [10:0]. It then checks the privilege level and either serves the access from local storage or forwards it to an external port.

The local storage includes the following registers:

- the floating-point control/status register
- the exception vector base
- the exception PC
- the exception effective address
- the exception status word
- a 64-bit multiply-accumulate register, reached as two 32-bit halves
- a banked shadow copy of the general registers
- the power-management register

Accesses to the translation buffers, the interrupt controller and the tick timer go out on the external port. A write to the next-PC number, and a power-management write that enables doze or sleep, ask the core to redirect its PC. The power-management case also raises a halt request, which is held until the wake input arrives. Read data and a response strobe appear one cycle after the request.

Top module: `sreg_access_unit`

## Requirements
- R1: The register number is {group, index}: group in bits [15:11], index in bits [10:0]. It is presented on `ext_addr` for forwarded accesses.
- R2: Group 0 index 20 (floating-point status) can be read and written whatever the value of `priv_super`.
- R3: Any other request made while `priv_super` is 0 produces a one-cycle `illegal_pulse` in the cycle after the request. It changes no register, and its read data is `req_rd_old`.
- R4: A read of a number that maps to nothing returns `req_rd_old` unchanged. This includes group 0 index 5, group 0 index 1536, and a forwarded read with `ext_hit` low.
- R5: Group 5 index 1 holds accumulator bits [31:0] and group 5 index 2 holds bits [63:32]. Writing one half leaves the other half intact.
- R6: Shadow entries occupy group 0 indices 1024 to 1535. Offset k = index-1024 selects bank k/32, entry k%32, and every entry holds its own value.
- R7: A write to group 0 index 16 pulses `pc_load` and `delay_clear`, with `pc_value` equal to the written data, only when that data differs from `pc_in`. Reading the same number returns `pc_in`.
- R8: A write to group 8 index 0 with bit 4 (doze) or bit 5 (sleep) set pulses `pc_load` with `pc_value` = `pc_in`+4. It also sets `halt_req`, which stays high until `wake` is 1 at a clock edge. A write with neither bit set does neither.
- R9: Group 0 indices 11, 32, 48 and 64 are plain 32-bit read/write registers.
- R10: After reset the exception vector base reads `EVBAR_RESET` (default 0x100). Every other register reads 0, and all strobes and `halt_req` are 0.
- R11: `resp_valid` is high in the cycle after each request, and `resp_rdata` carries that request's read data (0 for writes).
- R12: `ext_valid` is high in the request cycle only for permitted accesses to groups 1, 2, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_group | input | 5 | Register group |
| req_index | input | 11 | Register index within the group |
| req_wdata | input | 32 | Write data |
| req_rd_old | input | 32 | Current value of the destination register |
| priv_super | input | 1 | Supervisor mode bit |
| pc_in | input | 32 | Current PC of the requesting instruction |
| wake | input | 1 | Clears the halt request |
| ext_rdata | input | 32 | External read data |
| ext_hit | input | 1 | External side implements the forwarded number |
| resp_valid | output | 1 | Response strobe |
| resp_rdata | output | 32 | Read result |
| illegal_pulse | output | 1 | Illegal-instruction strobe |
| pc_load | output | 1 | PC redirect strobe |
| pc_value | output | 32 | New PC for the redirect |
| delay_clear | output | 1 | Clear pending delay-slot state |
| halt_req | output | 1 | Halt request, held until wake |
| ext_valid | output | 1 | Forwarded access strobe |
| ext_write | output | 1 | Forwarded access is a write |
| ext_addr | output | 16 | Forwarded register number |
| ext_wdata | output | 32 | Forwarded write data |

## Verification
On every cycle, the assertions check the following:

- the response strobe follows each request by one cycle;
- the illegal strobe appears exactly after unprivileged accesses other than floating-point status;
- forwarded accesses carry the joined register number and never happen in user mode;
- a PC redirect only follows a privileged write;
- the halt request holds until wake.

Register contents cannot be checked this way and are shown only by the bench's scenarios. These include the independence of the accumulator halves, the bank and entry split of the shadow file, the return of the old destination value for unmapped numbers, and the compare against the current PC on next-PC writes.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int GRP_W  = 5;
   localparam int IDX_W  = 11;
   localparam int ADDR_W = GRP_W + IDX_W;

   localparam int PM_DOZE_BIT  = 4;
   localparam int PM_SLEEP_BIT = 5;

   typedef enum logic [3:0] {
      TGT_NONE,
      TGT_FPSTAT,
      TGT_VBASE,
      TGT_NEXTPC,
      TGT_XPC,
      TGT_XADDR,
      TGT_XSTAT,
      TGT_SHADOW,
      TGT_ACC_LO,
      TGT_ACC_HI,
      TGT_PWR,
      TGT_EXT
   } sreg_tgt_e;

   function automatic logic [ADDR_W-1:0] sreg_num(input int unsigned grp, input int unsigned idx);
      return ADDR_W'((grp << IDX_W) + idx);
   endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
   import sreg_pkg::*;
#(
   parameter int SHADOW_BASE  = 1024,
   parameter int SHADOW_COUNT = 512
) (
   input  logic [GRP_W-1:0] grp,
   input  logic [IDX_W-1:0] idx,
   output sreg_tgt_e        tgt
);
   localparam int SH_END = SHADOW_BASE + SHADOW_COUNT;

   logic [ADDR_W-1:0] num;
   logic              in_shadow;

   assign num       = {grp, idx};
   assign in_shadow = (grp == '0) && (int'(idx) >= SHADOW_BASE) && (int'(idx) < SH_END)
                      && (SHADOW_COUNT > 0);

   always_comb begin
      tgt = TGT_NONE;
      if (in_shadow) begin
         tgt = TGT_SHADOW;
      end else begin
         case (grp)
            5'd1, 5'd2, 5'd9, 5'd10: tgt = TGT_EXT;
            default: begin
               if      (num == sreg_num(0, 20))  tgt = TGT_FPSTAT;
               else if (num == sreg_num(0, 11))  tgt = TGT_VBASE;
               else if (num == sreg_num(0, 16))  tgt = TGT_NEXTPC;
               else if (num == sreg_num(0, 32))  tgt = TGT_XPC;
               else if (num == sreg_num(0, 48))  tgt = TGT_XADDR;
               else if (num == sreg_num(0, 64))  tgt = TGT_XSTAT;
               else if (num == sreg_num(5, 1))   tgt = TGT_ACC_LO;
               else if (num == sreg_num(5, 2))   tgt = TGT_ACC_HI;
               else if (num == sreg_num(8, 0))   tgt = TGT_PWR;
               else                              tgt = TGT_NONE;
            end
         endcase
      end
   end

endmodule

// File: rtl/sreg_shadow_file.sv
module sreg_shadow_file #(
   parameter int BANKS = 16,
   parameter int REGS  = 32,
   parameter int DW    = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [$clog2(BANKS*REGS)-1:0]     off,
   input  logic [DW-1:0]                     wdata,
   output logic [DW-1:0]                     rdata
);
   localparam int OFF_W = $clog2(BANKS*REGS);
   localparam int BK_W  = (BANKS > 1) ? $clog2(BANKS) : 1;
   localparam int RG_W  = (REGS > 1) ? $clog2(REGS) : 1;

   logic [DW-1:0]   mem [BANKS][REGS];
   logic [BK_W-1:0] bank;
   logic [RG_W-1:0] ent;

   assign bank  = BK_W'(int'(off) / REGS);
   assign ent   = RG_W'(int'(off) % REGS);
   assign rdata = mem[bank][ent];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < BANKS; b++)
            for (int r = 0; r < REGS; r++)
               mem[b][r] <= '0;
      end else if (we) begin
         mem[bank][ent] <= wdata;
      end
   end

   logic unused_off;
   assign unused_off = ^{off, OFF_W[0]};

endmodule

// File: rtl/sreg_core_regs.sv
module sreg_core_regs
   import sreg_pkg::*;
#(
   parameter int          DW          = 32,
   parameter logic [31:0] EVBAR_RESET = 32'h0000_0100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  sreg_tgt_e     tgt,
   input  logic [DW-1:0] wdata,
   input  logic          wake,
   output logic [DW-1:0] fpstat,
   output logic [DW-1:0] vbase,
   output logic [DW-1:0] xpc,
   output logic [DW-1:0] xaddr,
   output logic [DW-1:0] xstat,
   output logic [DW-1:0] acc_lo,
   output logic [DW-1:0] acc_hi,
   output logic [DW-1:0] pwr,
   output logic          halt_req
);
   logic halt_set;

   assign halt_set = wr_en && (tgt == TGT_PWR)
                     && (wdata[PM_DOZE_BIT] || wdata[PM_SLEEP_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpstat <= '0;
         vbase  <= DW'(EVBAR_RESET);
         xpc    <= '0;
         xaddr  <= '0;
         xstat  <= '0;
         acc_lo <= '0;
         acc_hi <= '0;
         pwr    <= '0;
      end else if (wr_en) begin
         case (tgt)
            TGT_FPSTAT: fpstat <= wdata;
            TGT_VBASE:  vbase  <= wdata;
            TGT_XPC:    xpc    <= wdata;
            TGT_XADDR:  xaddr  <= wdata;
            TGT_XSTAT:  xstat  <= wdata;
            TGT_ACC_LO: acc_lo <= wdata;
            TGT_ACC_HI: acc_hi <= wdata;
            TGT_PWR:    pwr    <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        halt_req <= 1'b0;
      else if (halt_set) halt_req <= 1'b1;
      else if (wake)     halt_req <= 1'b0;
   end

endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
   import sreg_pkg::*;
#(
   parameter int          DW            = 32,
   parameter logic [31:0] EVBAR_RESET   = 32'h0000_0100,
   parameter bit          SHADOW_EN     = 1'b1,
   parameter int          SHADOW_BASE   = 1024,
   parameter int          SHADOW_BANKS  = 16,
   parameter int          SHADOW_REGS   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [4:0]    req_group,
   input  logic [10:0]   req_index,
   input  logic [31:0]   req_wdata,
   input  logic [31:0]   req_rd_old,
   input  logic          priv_super,
   input  logic [31:0]   pc_in,
   input  logic          wake,
   input  logic [31:0]   ext_rdata,
   input  logic          ext_hit,
   output logic          resp_valid,
   output logic [31:0]   resp_rdata,
   output logic          illegal_pulse,
   output logic          pc_load,
   output logic [31:0]   pc_value,
   output logic          delay_clear,
   output logic          halt_req,
   output logic          ext_valid,
   output logic          ext_write,
   output logic [15:0]   ext_addr,
   output logic [31:0]   ext_wdata
);
   localparam int SH_COUNT = SHADOW_EN ? SHADOW_BANKS * SHADOW_REGS : 0;
   localparam int SH_OFF_W = $clog2(SHADOW_BANKS * SHADOW_REGS);

   if (DW != 32) begin : g_bad_dw
      $error("sreg_access_unit: DW must be 32");
   end
   if (SHADOW_BANKS * SHADOW_REGS > 2048) begin : g_bad_shadow
      $error("sreg_access_unit: shadow file larger than 2048 entries");
   end
   if (SHADOW_BASE + SHADOW_BANKS * SHADOW_REGS > 2048) begin : g_bad_base
      $error("sreg_access_unit: shadow range exceeds index space");
   end

   sreg_tgt_e          tgt;
   logic               allowed;
   logic               acc_ok;
   logic               wr_ok;
   logic               pm_sleep;
   logic               npc_moves;
   logic [DW-1:0]      rd_mux;
   logic [DW-1:0]      sh_rdata;
   logic [SH_OFF_W-1:0] sh_off;
   logic [DW-1:0]      fpstat, vbase, xpc, xaddr, xstat, acc_lo, acc_hi, pwr;

   sreg_decode #(
      .SHADOW_BASE  (SHADOW_BASE),
      .SHADOW_COUNT (SH_COUNT)
   ) u_decode (
      .grp (req_group),
      .idx (req_index),
      .tgt (tgt)
   );

   assign allowed   = priv_super || (tgt == TGT_FPSTAT);
   assign acc_ok    = req_valid && allowed;
   assign wr_ok     = acc_ok && req_write;
   assign pm_sleep  = req_wdata[PM_DOZE_BIT] || req_wdata[PM_SLEEP_BIT];
   assign npc_moves = req_wdata != pc_in;
   assign sh_off    = SH_OFF_W'(int'(req_index) - SHADOW_BASE);

   sreg_core_regs #(
      .DW          (DW),
      .EVBAR_RESET (EVBAR_RESET)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .tgt      (tgt),
      .wdata    (req_wdata),
      .wake     (wake),
      .fpstat   (fpstat),
      .vbase    (vbase),
      .xpc      (xpc),
      .xaddr    (xaddr),
      .xstat    (xstat),
      .acc_lo   (acc_lo),
      .acc_hi   (acc_hi),
      .pwr      (pwr),
      .halt_req (halt_req)
   );

   if (SHADOW_EN) begin : g_shadow
      sreg_shadow_file #(
         .BANKS (SHADOW_BANKS),
         .REGS  (SHADOW_REGS),
         .DW    (DW)
      ) u_shadow (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_ok && (tgt == TGT_SHADOW)),
         .off   (sh_off),
         .wdata (req_wdata),
         .rdata (sh_rdata)
      );
   end else begin : g_no_shadow
      assign sh_rdata = '0;
   end

   assign ext_valid = acc_ok && (tgt == TGT_EXT);
   assign ext_write = req_write;
   assign ext_addr  = {req_group, req_index};
   assign ext_wdata = req_wdata;

   always_comb begin
      case (tgt)
         TGT_FPSTAT: rd_mux = fpstat;
         TGT_VBASE:  rd_mux = vbase;
         TGT_NEXTPC: rd_mux = pc_in;
         TGT_XPC:    rd_mux = xpc;
         TGT_XADDR:  rd_mux = xaddr;
         TGT_XSTAT:  rd_mux = xstat;
         TGT_SHADOW: rd_mux = sh_rdata;
         TGT_ACC_LO: rd_mux = acc_lo;
         TGT_ACC_HI: rd_mux = acc_hi;
         TGT_PWR:    rd_mux = pwr;
         TGT_EXT:    rd_mux = ext_hit ? ext_rdata : req_rd_old;
         default:    rd_mux = req_rd_old;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid    <= 1'b0;
         resp_rdata    <= '0;
         illegal_pulse <= 1'b0;
         pc_load       <= 1'b0;
         pc_value      <= '0;
         delay_clear   <= 1'b0;
      end else begin
         resp_valid    <= req_valid;
         illegal_pulse <= req_valid && !allowed;
         if (req_valid) begin
            if (!allowed)       resp_rdata <= req_rd_old;
            else if (req_write) resp_rdata <= '0;
            else                resp_rdata <= rd_mux;
         end
         pc_load     <= wr_ok && (((tgt == TGT_NEXTPC) && npc_moves)
                                  || ((tgt == TGT_PWR) && pm_sleep));
         delay_clear <= wr_ok && (tgt == TGT_NEXTPC) && npc_moves;
         if (wr_ok && (tgt == TGT_PWR))    pc_value <= pc_in + 32'd4;
         else if (wr_ok && (tgt == TGT_NEXTPC)) pc_value <= req_wdata;
      end
   end

endmodule

// File: rtl/sreg_access_chk.sv
module sreg_access_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [4:0]  req_group,
   input logic [10:0] req_index,
   input logic        priv_super,
   input logic        wake,
   input logic        resp_valid,
   input logic        illegal_pulse,
   input logic        pc_load,
   input logic        halt_req,
   input logic        ext_valid,
   input logic [15:0] ext_addr
);
   logic past_ok;
   logic fp_num;

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign fp_num = (req_group == 5'd0) && (req_index == 11'd20);

   assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (resp_valid == $past(req_valid)));

   assert_illegal_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (illegal_pulse == $past(req_valid && !priv_super && !fp_num)));

   assert_fp_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && fp_num) |=> !illegal_pulse);

   assert_ext_priv_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> (req_valid && priv_super));

   assert_ext_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> (ext_addr[15:11] == req_group && ext_addr[10:0] == req_index));

   assert_redirect_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && pc_load |-> $past(req_valid && req_write && priv_super));

   assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !wake) |=> halt_req);

endmodule

bind sreg_access_unit sreg_access_chk u_chk (.*);

// File: tb/sreg_access_unit_tb.sv
module sreg_access_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_group = '0;
   logic [10:0] req_index = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] req_rd_old = '0;
   logic        priv_super = 1'b1;
   logic [31:0] pc_in = 32'h0000_1000;
   logic        wake = 1'b0;
   logic [31:0] ext_rdata = 32'h0000_FEED;
   logic        ext_hit = 1'b1;
   logic        resp_valid, illegal_pulse, pc_load, delay_clear, halt_req;
   logic        ext_valid, ext_write;
   logic [31:0] resp_rdata, pc_value, ext_wdata;
   logic [15:0] ext_addr;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic        s_ext_valid;
   logic [15:0] s_ext_addr;

   always #4 clk = ~clk;

   sreg_access_unit u_dut (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic xfer(input bit wr, input int g, input int i, input logic [31:0] wd,
                       input logic [31:0] rd_old);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_group  = 5'(g);
      req_index  = 11'(i);
      req_wdata  = wd;
      req_rd_old = rd_old;
      #1;
      s_ext_valid = ext_valid;
      s_ext_addr  = ext_addr;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R10 resp_valid", 32'(resp_valid), 0);
      chk("R10 halt_req", 32'(halt_req), 0);
      chk("R10 illegal", 32'(illegal_pulse), 0);
      xfer(0, 0, 11, 0, 32'h5555_5555);
      chk("R10 vector base reset", resp_rdata, 32'h0000_0100);
      chk("R11 resp_valid after read", 32'(resp_valid), 1);
      xfer(0, 0, 32, 0, 32'h5555_5555);
      chk("R10 exception pc reset", resp_rdata, 0);
      xfer(0, 5, 2, 0, 32'h5555_5555);
      chk("R10 acc hi reset", resp_rdata, 0);
      idle();
      chk("R11 resp_valid idle", 32'(resp_valid), 0);
   endtask

   task automatic t_fp_user();
      priv_super = 1'b0;
      xfer(1, 0, 20, 32'h0000_00A5, 0);
      chk("R2 no illegal on fp write", 32'(illegal_pulse), 0);
      xfer(0, 0, 20, 0, 32'h1111_1111);
      chk("R2 fp readback user", resp_rdata, 32'h0000_00A5);
      chk("R2 no illegal on fp read", 32'(illegal_pulse), 0);
      priv_super = 1'b1;
   endtask

   task automatic t_user_block();
      priv_super = 1'b0;
      xfer(1, 0, 32, 32'h0000_1234, 0);
      chk("R3 illegal on user write", 32'(illegal_pulse), 1);
      idle();
      chk("R3 illegal single cycle", 32'(illegal_pulse), 0);
      xfer(0, 0, 32, 0, 32'h0BAD_0BAD);
      chk("R3 user read gives old", resp_rdata, 32'h0BAD_0BAD);
      xfer(1, 10, 0, 32'h1, 0);
      chk("R12 no forward in user mode", 32'(s_ext_valid), 0);
      xfer(1, 8, 0, 32'h10, 0);
      chk("R3 user pwr write no halt", 32'(halt_req), 0);
      chk("R3 user pwr write no redirect", 32'(pc_load), 0);
      priv_super = 1'b1;
      xfer(0, 0, 32, 0, 32'hFFFF_FFFF);
      chk("R3 exception pc untouched", resp_rdata, 0);
   endtask

   task automatic t_plain();
      xfer(1, 0, 11, 32'h0000_8000, 0);
      xfer(1, 0, 32, 32'hC0DE_0001, 0);
      xfer(1, 0, 48, 32'hC0DE_0002, 0);
      xfer(1, 0, 64, 32'hC0DE_0003, 0);
      xfer(0, 0, 11, 0, 0);
      chk("R9 vector base", resp_rdata, 32'h0000_8000);
      xfer(0, 0, 32, 0, 0);
      chk("R9 exception pc", resp_rdata, 32'hC0DE_0001);
      xfer(0, 0, 48, 0, 0);
      chk("R9 exception addr", resp_rdata, 32'hC0DE_0002);
      xfer(0, 0, 64, 0, 0);
      chk("R9 exception status", resp_rdata, 32'hC0DE_0003);
   endtask

   task automatic t_acc();
      xfer(1, 5, 1, 32'h1111_1111, 0);
      xfer(1, 5, 2, 32'h2222_2222, 0);
      xfer(1, 5, 1, 32'h3333_3333, 0);
      xfer(0, 5, 2, 0, 0);
      chk("R5 hi kept after lo write", resp_rdata, 32'h2222_2222);
      xfer(0, 5, 1, 0, 0);
      chk("R5 lo value", resp_rdata, 32'h3333_3333);
   endtask

   task automatic t_shadow();
      xfer(1, 0, 1024, 32'hAAAA_0000, 0);
      xfer(1, 0, 1024 + 33, 32'h0000_BBBB, 0);
      xfer(1, 0, 1024 + 1, 32'h0000_0001, 0);
      xfer(1, 0, 1535, 32'h0000_CCCC, 0);
      xfer(0, 0, 1024, 0, 0);
      chk("R6 bank0 entry0", resp_rdata, 32'hAAAA_0000);
      xfer(0, 0, 1024 + 33, 0, 0);
      chk("R6 bank1 entry1", resp_rdata, 32'h0000_BBBB);
      xfer(0, 0, 1024 + 1, 0, 0);
      chk("R6 bank0 entry1 distinct", resp_rdata, 32'h0000_0001);
      xfer(0, 0, 1535, 0, 0);
      chk("R6 last entry", resp_rdata, 32'h0000_CCCC);
      xfer(0, 0, 1536, 0, 32'hDEAD_0001);
      chk("R4 past shadow end", resp_rdata, 32'hDEAD_0001);
      xfer(0, 0, 5, 0, 32'hDEAD_0002);
      chk("R4 unmapped group0", resp_rdata, 32'hDEAD_0002);
   endtask

   task automatic t_nextpc();
      xfer(1, 0, 16, 32'h0000_1000, 0);
      chk("R7 same pc no redirect", 32'(pc_load), 0);
      chk("R7 same pc no delay clear", 32'(delay_clear), 0);
      xfer(1, 0, 16, 32'h0000_2000, 0);
      chk("R7 redirect", 32'(pc_load), 1);
      chk("R7 delay clear", 32'(delay_clear), 1);
      chk("R7 new pc", pc_value, 32'h0000_2000);
      xfer(0, 0, 16, 0, 0);
      chk("R7 read gives pc_in", resp_rdata, 32'h0000_1000);
   endtask

   task automatic t_power();
      xfer(1, 8, 0, 32'h0000_0001, 0);
      chk("R8 no halt without doze/sleep", 32'(halt_req), 0);
      chk("R8 no redirect without doze/sleep", 32'(pc_load), 0);
      xfer(0, 8, 0, 0, 0);
      chk("R8 pwr readback", resp_rdata, 32'h0000_0001);
      xfer(1, 8, 0, 32'h0000_0010, 0);
      chk("R8 doze halt", 32'(halt_req), 1);
      chk("R8 redirect", 32'(pc_load), 1);
      chk("R8 pc plus 4", pc_value, 32'h0000_1004);
      idle(); idle();
      chk("R8 halt held", 32'(halt_req), 1);
      @(negedge clk); wake = 1'b1;
      @(posedge clk); #1; wake = 1'b0;
      chk("R8 wake clears", 32'(halt_req), 0);
      xfer(1, 8, 0, 32'h0000_0020, 0);
      chk("R8 sleep halt", 32'(halt_req), 1);
      @(negedge clk); wake = 1'b1;
      @(posedge clk); #1; wake = 1'b0;
   endtask

   task automatic t_ext();
      ext_hit = 1'b1;
      xfer(0, 9, 2, 0, 32'h7777_7777);
      chk("R12 forward group9", 32'(s_ext_valid), 1);
      chk("R1 joined number", 32'(s_ext_addr), 32'h0000_4802);
      chk("R12 ext read data", resp_rdata, 32'h0000_FEED);
      ext_hit = 1'b0;
      xfer(0, 2, 600, 0, 32'h7777_7777);
      chk("R1 joined number group2", 32'(s_ext_addr), 32'h0000_1258);
      chk("R4 ext miss gives old", resp_rdata, 32'h7777_7777);
      ext_hit = 1'b1;
      xfer(0, 5, 1, 0, 0);
      chk("R12 no forward group5", 32'(s_ext_valid), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_fp_user();
      t_user_block();
      t_plain();
      t_acc();
      t_shadow();
      t_nextpc();
      t_power();
      t_ext();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule